// File: doc/BRIEF.md
# Daisy-Chain Grant Slot with Passive Release

This block is the bus-grant logic for one peripheral slot on a daisy-chained bus. Several interrupt priority levels and one DMA level each have a grant line. Each grant line comes in from the upstream slot and leaves toward the downstream slot. For every level the block decides, on the cycle the grant arrives, whether to pass the grant on or capture it. When it captures a grant, it raises a shared selection-acknowledge output. While a level is not capturing, the grant path through the slot is purely combinational, so a whole chain settles within one clock period.

A configuration input enables a passive-release mode. In this mode the slot captures an interrupt grant that it does not need, but only while some DMA request is pending on the bus. It acknowledges the grant and then lets go once the arbiter withdraws it. It never uses the bus in that case, so the arbiter can move on to the DMA grant sooner. A second configuration input models the DMA pass-through link. When the link is left intact, the slot captures every DMA grant. An idle/internal-reset input returns the slot to free pass-through.

Top module: `daisy_grant_slot`

## Requirements
- R1: With no capture in progress and no local request at a level, `bg_o` of that level follows `bg_i` in the same cycle and `sack_o` stays 0. A request at one level does not affect the grant of any other level.
- R2: A grant that arrives at a level with its `irq_req_i` bit set is blocked at once (`bg_o` bit 0 while `bg_i` bit 1). `sack_o` is 1 from the next rising clock edge.
- R3: After a grant is captured for the slot's own use, `sack_o` stays 1 until both the grant and the request are low at a clock edge. It is 0 after that edge.
- R4: With `passive_en_i`=1 and `bus_npr_i`=1, an interrupt grant at a level with no local request is blocked and acknowledged. `sack_o` falls at the first clock edge at which that grant is low.
- R5: With `passive_en_i`=0, a pending `bus_npr_i` alone does not capture an interrupt grant: the grant passes downstream and `sack_o` stays 0.
- R6: Passive release never applies to the DMA grant. With `npg_link_cut_i`=1 and `dma_req_i`=0, `npg_o` follows `npg_i` whatever `passive_en_i` and `bus_npr_i` are. With `dma_req_i`=1, the DMA grant is captured and acknowledged as in R2/R3.
- R7: While `idle_i`=1, every grant output equals its grant input in the same cycle. `sack_o` is 0 from the next clock edge on.
- R8: With `npg_link_cut_i`=0, the slot captures a DMA grant even with no DMA request. `sack_o` is 1 from the next edge and falls at the first edge at which `npg_i` is low.
- R9: Once a grant has been passed downstream at a clock edge, it stays passed until `bg_i`/`npg_i` falls, even if a local request rises meanwhile.
- R10: While `rst_ni`=0, `sack_o` is 0 and, with no requests, grants pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Internal reset / idle: force pass-through, clear captures |
| passive_en_i | input | 1 | Enable passive release of interrupt grants |
| npg_link_cut_i | input | 1 | 1 = DMA pass-through link cut (normal); 0 = slot captures DMA grants |
| bus_npr_i | input | 1 | A DMA request is pending somewhere on the bus |
| irq_req_i | input | NUM_LEVELS | Local interrupt request, one bit per level |
| dma_req_i | input | 1 | Local DMA request |
| bg_i | input | NUM_LEVELS | Interrupt grants from upstream, bit i = level i |
| bg_o | output | NUM_LEVELS | Interrupt grants to downstream |
| npg_i | input | 1 | DMA grant from upstream |
| npg_o | output | 1 | DMA grant to downstream |
| sack_o | output | 1 | Selection acknowledge |

## Verification
Several corner cases are covered. A request that rises after a grant has already gone downstream must not take the grant back; a design that re-decided each cycle would chop the downstream grant. Passive release must follow all three inputs: a design that ignored the enable would stall interrupt grants whenever DMA is pending, and one that applied it to the DMA level would swallow DMA grants. The slot's own captures must hold acknowledge until the request is gone, while passive captures must drop it on grant withdrawal; mixing these up either hangs the bus or cuts a transfer short. Idle must restore pass-through combinationally even in the middle of a capture.

// File: rtl/grant_pkg.sv
package grant_pkg;
  typedef enum logic [1:0] {
    LVL_FREE = 2'd0,  // no grant seen yet, decides combinationally
    LVL_PASS = 2'd1,  // grant committed downstream
    LVL_OWN  = 2'd2,  // captured for own use
    LVL_DROP = 2'd3   // captured only to be released
  } lvl_state_e;
endpackage

// File: rtl/grant_level.sv
module grant_level
  import grant_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic gnt_i,
  input  logic want_use_i,
  input  logic want_drop_i,
  input  logic busy_i,
  output logic gnt_o,
  output logic ack_o
);
  lvl_state_e state_q, state_d;
  logic want;

  assign want = want_use_i | want_drop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LVL_FREE: if (gnt_i) state_d = want_use_i ? LVL_OWN : (want_drop_i ? LVL_DROP : LVL_PASS);
      LVL_PASS: if (!gnt_i) state_d = LVL_FREE;
      LVL_DROP: if (!gnt_i) state_d = LVL_FREE;
      LVL_OWN:  if (!gnt_i && !busy_i) state_d = LVL_FREE;
      default:  state_d = LVL_FREE;
    endcase
    if (idle_i) state_d = LVL_FREE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LVL_FREE;
    else         state_q <= state_d;
  end

  // bypass path stays combinational unless a capture is pending
  assign gnt_o = gnt_i & (idle_i | (state_q == LVL_PASS) | ((state_q == LVL_FREE) & ~want));
  assign ack_o = (state_q == LVL_OWN) | (state_q == LVL_DROP);
endmodule

// File: rtl/grant_ack_or.sv
module grant_ack_or #(
  parameter int unsigned NUM_CH = 5
) (
  input  logic [NUM_CH-1:0] ack_i,
  output logic              ack_o
);
  assign ack_o = |ack_i;
endmodule

// File: rtl/daisy_grant_slot.sv
module daisy_grant_slot #(
  parameter int unsigned NUM_LEVELS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  idle_i,
  input  logic                  passive_en_i,
  input  logic                  npg_link_cut_i,
  input  logic                  bus_npr_i,
  input  logic [NUM_LEVELS-1:0] irq_req_i,
  input  logic                  dma_req_i,
  input  logic [NUM_LEVELS-1:0] bg_i,
  output logic [NUM_LEVELS-1:0] bg_o,
  input  logic                  npg_i,
  output logic                  npg_o,
  output logic                  sack_o
);
  localparam int unsigned NUM_CH = NUM_LEVELS + 1;

  logic [NUM_CH-1:0] ack;
  logic              drop_irq;

  assign drop_irq = passive_en_i & bus_npr_i;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_irq
    grant_level u_lvl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idle_i     (idle_i),
      .gnt_i      (bg_i[l]),
      .want_use_i (irq_req_i[l]),
      .want_drop_i(drop_irq),
      .busy_i     (irq_req_i[l]),
      .gnt_o      (bg_o[l]),
      .ack_o      (ack[l])
    );
  end

  // DMA level: an uncut link captures every grant, passive release never applies
  grant_level u_dma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle_i),
    .gnt_i      (npg_i),
    .want_use_i (dma_req_i),
    .want_drop_i(~npg_link_cut_i),
    .busy_i     (dma_req_i),
    .gnt_o      (npg_o),
    .ack_o      (ack[NUM_LEVELS])
  );

  grant_ack_or #(.NUM_CH(NUM_CH)) u_ack (
    .ack_i(ack),
    .ack_o(sack_o)
  );
endmodule

// File: rtl/daisy_grant_slot_chk.sv
module daisy_grant_slot_chk #(
  parameter int unsigned NUM_LEVELS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  idle_i,
  input logic                  npg_link_cut_i,
  input logic                  dma_req_i,
  input logic [NUM_LEVELS-1:0] bg_i,
  input logic [NUM_LEVELS-1:0] bg_o,
  input logic                  npg_i,
  input logic                  npg_o,
  input logic                  sack_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_no_spurious_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bg_o & ~bg_i) == '0) && !(npg_o && !npg_i));

  assert_idle_clears_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(idle_i) |-> !sack_o);

  assert_ack_needs_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $rose(sack_o) |-> $past((|bg_i) || npg_i));

  assert_dma_no_passive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!npg_i && !dma_req_i) && npg_i && npg_link_cut_i && !dma_req_i |-> npg_o);

  assert_pass_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !idle_i && !$past(idle_i) |-> (($past(bg_o & bg_i) & bg_i & ~bg_o) == '0));
endmodule

bind daisy_grant_slot daisy_grant_slot_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .idle_i        (idle_i),
  .npg_link_cut_i(npg_link_cut_i),
  .dma_req_i     (dma_req_i),
  .bg_i          (bg_i),
  .bg_o          (bg_o),
  .npg_i         (npg_i),
  .npg_o         (npg_o),
  .sack_o        (sack_o)
);

// File: tb/daisy_grant_slot_test.sv
module daisy_grant_slot_test;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          idle = 1'b0, passive_en = 1'b0, link_cut = 1'b1, bus_npr = 1'b0;
  logic [NL-1:0] irq_req = '0, bg_in = '0;
  logic [NL-1:0] bg_out;
  logic          dma_req = 1'b0, npg_in = 1'b0;
  logic          npg_out, sack;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  daisy_grant_slot #(.NUM_LEVELS(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .idle_i(idle), .passive_en_i(passive_en),
    .npg_link_cut_i(link_cut), .bus_npr_i(bus_npr), .irq_req_i(irq_req),
    .dma_req_i(dma_req), .bg_i(bg_in), .bg_o(bg_out), .npg_i(npg_in),
    .npg_o(npg_out), .sack_o(sack)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    bg_in = 4'b1010; npg_in = 1'b1; settle();
    chk("R10", "bg_o in reset", 32'(bg_out), 32'hA);
    chk("R10", "npg_o in reset", 32'(npg_out), 32'h1);
    chk("R10", "sack in reset", 32'(sack), 32'h0);
    bg_in = '0; npg_in = 1'b0;
    tick(); rst_n = 1'b1; tick();
  endtask

  task automatic t_pass();
    irq_req = 4'b0010; bg_in = 4'b0100; settle();
    chk("R1", "bg_o pass other level", 32'(bg_out), 32'h4);
    tick();
    chk("R1", "sack stays low", 32'(sack), 32'h0);
    chk("R1", "bg_o held", 32'(bg_out), 32'h4);
    bg_in = '0; irq_req = '0; tick();
  endtask

  task automatic t_own();
    irq_req = 4'b0100; bg_in = 4'b0100; settle();
    chk("R2", "bg_o blocked", 32'(bg_out), 32'h0);
    chk("R2", "sack before edge", 32'(sack), 32'h0);
    tick();
    chk("R2", "sack after edge", 32'(sack), 32'h1);
    bg_in = '0; tick();
    chk("R3", "sack held while request", 32'(sack), 32'h1);
    irq_req = '0; tick();
    chk("R3", "sack released", 32'(sack), 32'h0);
  endtask

  task automatic t_passive();
    passive_en = 1'b1; bus_npr = 1'b1; bg_in = 4'b0001; settle();
    chk("R4", "bg_o blocked passive", 32'(bg_out), 32'h0);
    tick();
    chk("R4", "sack passive", 32'(sack), 32'h1);
    bg_in = '0; tick();
    chk("R4", "sack released on withdraw", 32'(sack), 32'h0);
    passive_en = 1'b0; bus_npr = 1'b0; tick();
  endtask

  task automatic t_passive_off();
    bus_npr = 1'b1; bg_in = 4'b1000; settle();
    chk("R5", "bg_o passes without enable", 32'(bg_out), 32'h8);
    tick();
    chk("R5", "no sack without enable", 32'(sack), 32'h0);
    bg_in = '0; bus_npr = 1'b0; tick();
  endtask

  task automatic t_dma();
    passive_en = 1'b1; bus_npr = 1'b1; npg_in = 1'b1; settle();
    chk("R6", "npg passes", 32'(npg_out), 32'h1);
    tick();
    chk("R6", "no sack on dma pass", 32'(sack), 32'h0);
    npg_in = 1'b0; tick();
    dma_req = 1'b1; npg_in = 1'b1; settle();
    chk("R6", "npg captured on request", 32'(npg_out), 32'h0);
    tick();
    chk("R6", "sack dma", 32'(sack), 32'h1);
    npg_in = 1'b0; dma_req = 1'b0; tick();
    chk("R6", "sack dma release", 32'(sack), 32'h0);
    passive_en = 1'b0; bus_npr = 1'b0;
  endtask

  task automatic t_uncut();
    link_cut = 1'b0; npg_in = 1'b1; settle();
    chk("R8", "npg blocked by uncut link", 32'(npg_out), 32'h0);
    tick();
    chk("R8", "sack uncut", 32'(sack), 32'h1);
    npg_in = 1'b0; tick();
    chk("R8", "sack uncut release", 32'(sack), 32'h0);
    link_cut = 1'b1; tick();
  endtask

  task automatic t_sticky();
    bg_in = 4'b0010; tick();
    irq_req = 4'b0010; settle();
    chk("R9", "grant stays passed", 32'(bg_out), 32'h2);
    tick();
    chk("R9", "grant still passed", 32'(bg_out), 32'h2);
    chk("R9", "no sack", 32'(sack), 32'h0);
    bg_in = '0; irq_req = '0; tick();
  endtask

  task automatic t_idle();
    irq_req = 4'b0001; bg_in = 4'b0001; tick();
    chk("R7", "captured before idle", 32'(sack), 32'h1);
    idle = 1'b1; settle();
    chk("R7", "bg_o passes under idle", 32'(bg_out), 32'h1);
    tick();
    chk("R7", "sack cleared by idle", 32'(sack), 32'h0);
    bg_in = '0; irq_req = '0; tick();
    idle = 1'b0; tick();
  endtask

  initial begin
    #5;
    t_reset();
    t_pass();
    t_own();
    t_passive();
    t_passive_off();
    t_dma();
    t_uncut();
    t_sticky();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule